// File: doc/BRIEF.md
# Segmented Address Translator with Store Protection

This block turns two 16-bit logical addresses into 18-bit physical addresses. One is the data address used for loads and stores and the other is the instruction-fetch address. It is purely combinational and sits between an address source and a memory made of eight 32K-word segments. A 16-bit configuration word holds four nibbles. Two nibbles serve instruction fetches and two serve data accesses. For each port, the top bit of the logical address picks either the lower-half nibble or the upper-half nibble of that port. The low three bits of the chosen nibble become the segment number. That number replaces the logical address's top bit, and the 15 offset bits are kept as they are.

The top bit of a data nibble is a write-protect flag. When the data address falls in a protected half, the incoming store request is blocked. When it falls in an unprotected half, the request goes through unchanged. Instruction nibbles have no protect flag, so their top bits are spare.

Top module: `seg_xlat`

## Requirements
- R1: When instAddr[15] is 0, instPhys equals {segCfg[2:0], instAddr[14:0]}.
- R2: When instAddr[15] is 1, instPhys equals {segCfg[6:4], instAddr[14:0]}.
- R3: When dataAddr[15] is 0, dataPhys equals {segCfg[10:8], dataAddr[14:0]}.
- R4: When dataAddr[15] is 1, dataPhys equals {segCfg[14:12], dataAddr[14:0]}.
- R5: Bits 14..0 of each physical address equal bits 14..0 of its logical address. Bit 15 of the logical address never appears in the physical address.
- R6: storeEn equals storeReq when the selected protect flag is 0. The flag is segCfg[11] when dataAddr[15] is 0 and segCfg[15] when dataAddr[15] is 1. storeEn is 0 when that flag is 1.
- R7: storeEn is never 1 while storeReq is 0.
- R8: The instruction address, including its bit 15, has no effect on storeEn or dataPhys.
- R9: segCfg[3] and segCfg[7] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dataAddr | input | 16 | Logical data address; bit 15 picks the data half |
| instAddr | input | 16 | Logical instruction-fetch address; bit 15 picks the fetch half |
| segCfg | input | 16 | Four 4-bit segment nibbles: fetch-low, fetch-high, data-low, data-high from bit 0 upward |
| storeReq | input | 1 | Store request for the data address |
| dataPhys | output | 18 | Translated data address |
| instPhys | output | 18 | Translated instruction address |
| storeEn | output | 1 | Store request after the write-protect gate |

## Verification
The bench sweeps both address top bits, both data protect flags and the store request. It pairs each combination with rotating segment numbers and offsets, so a design that swaps the lower and upper nibbles, or the fetch and data nibbles, shows the wrong segment bits. A gate that reads the protect flag of the wrong half, or of a fetch nibble, lets a store through in a protected half or drops one in an open half. The spare fetch-nibble bits and the fetch address top bit are toggled while everything else is held still, which exposes any leak of either into the data path or the store enable.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;
  // Port indices; each port owns two consecutive nibbles (low half, high half)
  localparam int NUM_PORTS  = 2;
  localparam int PORT_INST  = 0;
  localparam int PORT_DATA  = 1;
  localparam int NUM_FIELDS = 2 * NUM_PORTS;
  // Ports whose nibbles carry a write-protect flag
  localparam logic [NUM_PORTS-1:0] PORT_RO_MASK = 2'b10;

  typedef struct packed {
    logic [NUM_PORTS-1:0] halfSel; // 1 = use the upper-half nibble for that port
  } xlatStrobes_t;
endpackage

// File: rtl/seg_xlat_ctrl.sv
module seg_xlat_ctrl
  import seg_xlat_pkg::*;
(
  input  logic                  instMsb,
  input  logic                  dataMsb,
  input  logic [NUM_FIELDS-1:0] roFlags,
  input  logic                  storeReq,
  output xlatStrobes_t          strobes,
  output logic                  storeEn
);
  logic [NUM_PORTS-1:0] portMsb;
  logic [NUM_PORTS-1:0] roActive;

  assign portMsb[PORT_INST] = instMsb;
  assign portMsb[PORT_DATA] = dataMsb;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_ro
    // only ports that own a protect flag can block a store
    assign roActive[p] = PORT_RO_MASK[p] &
                         (portMsb[p] ? roFlags[2*p+1] : roFlags[2*p]);
  end

  assign strobes.halfSel = portMsb;
  assign storeEn         = storeReq & ~(|roActive);

  always_comb begin
    // R7
    store_needs_req_chk: assert (!(storeEn && !storeReq))
      else $error("store enabled without a request");
  end
endmodule

// File: rtl/seg_xlat_dp.sv
module seg_xlat_dp
  import seg_xlat_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SEG_W  = 3
) (
  input  logic [ADDR_W-2:0]       instOff,
  input  logic [ADDR_W-2:0]       dataOff,
  input  logic [SEG_W-1:0]        segFields [NUM_FIELDS],
  input  xlatStrobes_t            strobes,
  output logic [ADDR_W+SEG_W-2:0] instPhys,
  output logic [ADDR_W+SEG_W-2:0] dataPhys
);
  localparam int OFF_W  = ADDR_W - 1;
  localparam int PHYS_W = OFF_W + SEG_W;

  logic [OFF_W-1:0]  portOff  [NUM_PORTS];
  logic [PHYS_W-1:0] portPhys [NUM_PORTS];

  assign portOff[PORT_INST] = instOff;
  assign portOff[PORT_DATA] = dataOff;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [SEG_W-1:0] segPick;
    assign segPick     = strobes.halfSel[p] ? segFields[2*p+1] : segFields[2*p];
    assign portPhys[p] = {segPick, portOff[p]};
  end

  assign instPhys = portPhys[PORT_INST];
  assign dataPhys = portPhys[PORT_DATA];
endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
  import seg_xlat_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int SEG_W   = 3,
  parameter int FIELD_W = 4
) (
  input  logic [ADDR_W-1:0]             dataAddr,
  input  logic [ADDR_W-1:0]             instAddr,
  input  logic [NUM_FIELDS*FIELD_W-1:0] segCfg,
  input  logic                          storeReq,
  output logic [ADDR_W+SEG_W-2:0]       dataPhys,
  output logic [ADDR_W+SEG_W-2:0]       instPhys,
  output logic                          storeEn
);
  localparam int OFF_W  = ADDR_W - 1;
  localparam int PHYS_W = OFF_W + SEG_W;

  logic [SEG_W-1:0]      segFields [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] roFlags;
  xlatStrobes_t          strobes;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    assign segFields[f] = segCfg[f*FIELD_W +: SEG_W];
    assign roFlags[f]   = segCfg[f*FIELD_W + FIELD_W - 1];
  end

  seg_xlat_ctrl i_ctrl (
    .instMsb  (instAddr[ADDR_W-1]),
    .dataMsb  (dataAddr[ADDR_W-1]),
    .roFlags  (roFlags),
    .storeReq (storeReq),
    .strobes  (strobes),
    .storeEn  (storeEn)
  );

  seg_xlat_dp #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) i_dp (
    .instOff   (instAddr[OFF_W-1:0]),
    .dataOff   (dataAddr[OFF_W-1:0]),
    .segFields (segFields),
    .strobes   (strobes),
    .instPhys  (instPhys),
    .dataPhys  (dataPhys)
  );

  always_comb begin
    // R1
    inst_low_seg_chk: assert (instAddr[ADDR_W-1] ||
                              instPhys[PHYS_W-1 -: SEG_W] == segCfg[SEG_W-1:0])
      else $error("fetch low half used wrong segment");
    // R4
    data_high_seg_chk: assert (!dataAddr[ADDR_W-1] ||
                               dataPhys[PHYS_W-1 -: SEG_W] ==
                               segCfg[(2*PORT_DATA+1)*FIELD_W +: SEG_W])
      else $error("data high half used wrong segment");
    // R6
    data_high_ro_chk: assert (!(dataAddr[ADDR_W-1] &&
                                segCfg[NUM_FIELDS*FIELD_W-1] && storeEn))
      else $error("store passed into protected upper data half");
  end
endmodule

// File: tb/test_seg_xlat.sv
module test_seg_xlat;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] dataAddr, instAddr, segCfg;
  logic        storeReq;
  logic [17:0] dataPhys, instPhys;
  logic        storeEn;

  int  compared   = 0;
  int  mismatched = 0;
  bit  finished   = 1'b0;

  seg_xlat i_seg_xlat (
    .dataAddr (dataAddr),
    .instAddr (instAddr),
    .segCfg   (segCfg),
    .storeReq (storeReq),
    .dataPhys (dataPhys),
    .instPhys (instPhys),
    .storeEn  (storeEn)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] d, input logic [15:0] i,
                       input logic [15:0] m, input logic r);
    @(posedge clk);
    dataAddr = d; instAddr = i; segCfg = m; storeReq = r;
    @(negedge clk);
  endtask

  // Expected physical address: segment number times 32768 plus the 15-bit offset
  function automatic logic [31:0] expPhys(input logic [15:0] a, input logic [15:0] m,
                                          input int lowShift);
    int shift;
    shift = a[15] ? lowShift + 4 : lowShift;
    return ((32'(m) >> shift) % 8) * 32768 + (32'(a) % 32768);
  endfunction

  function automatic logic [31:0] expStore(input logic [15:0] a, input logic [15:0] m,
                                           input logic r);
    int flagPos;
    flagPos = a[15] ? 15 : 11;
    return (r && ((32'(m) >> flagPos) % 2 == 0)) ? 1 : 0;
  endfunction

  initial begin
    dataAddr = '0; instAddr = '0; segCfg = '0; storeReq = 1'b0;
    @(negedge clk);
    check("R7 idle storeEn", 32'(storeEn), 0);
    check("R1 idle instPhys", 32'(instPhys), 0);
    check("R3 idle dataPhys", 32'(dataPhys), 0);

    for (int k = 0; k < 1024; k++) begin
      logic [15:0] d, i, m, m2;
      logic        r;
      logic [2:0]  s;
      d = 16'((k * 4663 + 77) % 32768);
      i = 16'((k * 2917 + 5) % 32768);
      d[15] = k[0];
      i[15] = k[1];
      r     = k[2];
      s     = 3'(k >> 5);
      m = {k[4], s ^ 3'd3, k[3], s ^ 3'd5, k[7], s ^ 3'd6, k[6], s};
      drive(d, i, m, r);
      if (!i[15]) check("R1 instPhys low half", 32'(instPhys), expPhys(i, m, 0));
      else        check("R2 instPhys high half", 32'(instPhys), expPhys(i, m, 0));
      if (!d[15]) check("R3 dataPhys low half", 32'(dataPhys), expPhys(d, m, 8));
      else        check("R4 dataPhys high half", 32'(dataPhys), expPhys(d, m, 8));
      check("R5 data offset kept", 32'(dataPhys) % 32768, 32'(d) % 32768);
      check("R5 inst offset kept", 32'(instPhys) % 32768, 32'(i) % 32768);
      check("R6 store gate", 32'(storeEn), expStore(d, m, r));
      if (!r) check("R7 no store without request", 32'(storeEn), 0);

      if (k % 8 == 0) begin
        // R8: flip fetch address MSB, data side and store must not move
        drive(d, i ^ 16'h8000, m, r);
        check("R8 storeEn vs fetch MSB", 32'(storeEn), expStore(d, m, r));
        check("R8 dataPhys vs fetch MSB", 32'(dataPhys), expPhys(d, m, 8));
        // R9: flip spare bits 3 and 7
        m2 = m ^ 16'h0088;
        drive(d, i, m2, r);
        check("R9 instPhys spare bits", 32'(instPhys), expPhys(i, m, 0));
        check("R9 dataPhys spare bits", 32'(dataPhys), expPhys(d, m, 8));
        check("R9 storeEn spare bits", 32'(storeEn), expStore(d, m, r));
      end
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog (R1 run): got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule